// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker drives a transfer engine from a linked list of transfer descriptors held in memory. Software places the descriptors in memory, programs the address of the first one, sets the descriptor-mode enable and pulses submit. The walker reads each descriptor one 32-bit word at a time over a simple request/response read port. It stores the words and presents the decoded transfer command to the engine with a valid/ready handshake. It then waits for the engine's completion pulse. After that it either loads the descriptor named by the chain pointer or goes idle, depending on the descriptor's own flags.

A descriptor is twelve 32-bit words at consecutive byte addresses, four bytes apart. A 64-bit field occupies two words, with the low word first. The word order is:

| Words | Field |
|-------|-------|
| 0 | flags |
| 1 | id |
| 2, 3 | destination address |
| 4, 5 | source address |
| 6, 7 | next-descriptor address |
| 8 | row count for 2D transfers |
| 9 | bytes per row minus one |
| 10 | source stride |
| 11 | destination stride |

For 1D transfers the row count and both strides are zero. The walker passes these fields through unchanged. While descriptor mode is enabled, the host's request for cyclic repetition is masked off.

Top module: `dchain_walker`

## Requirements
- R1: After reset the block is idle: busy, irq, rd_req_valid and cmd_valid are all low.
- R2: A chain starts only on a submit pulse while cfg_desc_en is high. The first read request goes to cfg_head_addr. A submit pulse while cfg_desc_en is low starts nothing.
- R3: Each descriptor is fetched as twelve read requests at base + 4*k for k = 0..11, in increasing order. No new request is issued before the response to the previous one, and cmd_valid is never high together with rd_req_valid.
- R4: The command fields come from the descriptor words. cmd_dst is words 3:2, cmd_src is words 5:4, cmd_ylen is word 8, cmd_xlen is word 9 (byte count minus one, passed unchanged), cmd_src_stride is word 10 and cmd_dst_stride is word 11.
- R5: Once raised, cmd_valid stays high with stable command fields until cmd_ready is seen.
- R6: On xfer_done, if flags bit 0 (last) is set, the block returns to idle on the next cycle and issues no further reads. If the bit is clear, the next fetch reads from the next-descriptor address in words 7:6.
- R7: irq pulses high for exactly one cycle, in the cycle after xfer_done, only for a descriptor whose flags bit 1 is set. Flag bits 31:2 have no effect.
- R8: A submit pulse while a chain is active is ignored. The chain's read addresses and command count are unaffected.
- R9: busy is high from the cycle after the starting submit until the cycle after the last descriptor's xfer_done. While busy is low, no read request or command is presented.
- R10: cur_id carries word 1 (id) of the descriptor whose command is being presented or executed.
- R11: cyclic_active equals cfg_cyclic_req while cfg_desc_en is low, and it is low while cfg_desc_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_desc_en | input | 1 | Descriptor mode enable |
| cfg_cyclic_req | input | 1 | Host request for cyclic repetition |
| cfg_head_addr | input | ADDR_W | Address of the first descriptor |
| submit | input | 1 | One-cycle start strobe |
| cyclic_active | output | 1 | Cyclic repetition permitted |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of requested word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer engine accepts command |
| cmd_src | output | ADDR_W | Source address |
| cmd_dst | output | ADDR_W | Destination address |
| cmd_xlen | output | 32 | Bytes per row minus one |
| cmd_ylen | output | 32 | Row count for 2D, zero for 1D |
| cmd_src_stride | output | 32 | Source stride |
| cmd_dst_stride | output | 32 | Destination stride |
| xfer_done | input | 1 | Transfer engine finished current command |
| irq | output | 1 | End-of-segment interrupt pulse |
| busy | output | 1 | Chain in progress |
| cur_id | output | 32 | Id of current descriptor |

## Verification
The assertions assume the following about the inputs:
- The memory returns exactly one response per accepted request, and only after accepting it.
- The transfer engine pulses xfer_done only for a command it has accepted.

The bench's memory model meets the first assumption. It queues a response only after it sees a request handshake, delays it by a random zero to two cycles, and holds at most one response in flight. The engine model meets the second. It arms its completion counter only on a command handshake and emits one xfer_done per accepted command. The ready signals on both ports are randomized, so the assertions on held requests and held commands are exercised under back-pressure.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
   localparam int DESC_WORDS = 12;
   localparam int WORD_W     = 32;
   localparam int FLAG_LAST  = 0;
   localparam int FLAG_IRQ   = 1;

   typedef struct packed {
      logic [31:0] flags;
      logic [31:0] id;
      logic [63:0] dst;
      logic [63:0] src;
      logic [63:0] nxt;
      logic [31:0] ylen;
      logic [31:0] xlen;
      logic [31:0] sstride;
      logic [31:0] dstride;
   } desc_t;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE, ST_RUN} walk_st_t;
endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch #(
   parameter int ADDR_W = 64,
   parameter int N_WORDS = dcw_pkg::DESC_WORDS,
   localparam int IDX_W = $clog2(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [31:0]       rd_rsp_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [31:0]       wr_data,
   output logic              done
);
   generate
      if (N_WORDS < 2) begin : g_bad_words
         $error("dcw_fetch: N_WORDS must be at least 2");
      end
   endgenerate

   logic              active_q;
   logic              outst_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              last_word;

   assign last_word    = (idx_q == IDX_W'(N_WORDS - 1));
   assign rd_req_valid = active_q & ~outst_q;
   assign rd_req_addr  = base_q + ADDR_W'({idx_q, 2'b00});
   assign wr_en        = active_q & outst_q & rd_rsp_valid;
   assign wr_idx       = idx_q;
   assign wr_data      = rd_rsp_data;
   assign done         = wr_en & last_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         outst_q  <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         outst_q  <= 1'b0;
         idx_q    <= '0;
         base_q   <= base;
      end else begin
         if (rd_req_valid && rd_req_ready) outst_q <= 1'b1;
         if (wr_en) begin
            outst_q <= 1'b0;
            idx_q   <= idx_q + 1'b1;
            if (last_word) active_q <= 1'b0;
         end
      end
   end

   // A request not yet accepted keeps its address
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

   // After the final word no further request is raised
   assert_stop_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !rd_req_valid);
endmodule

// File: rtl/dcw_unpack.sv
module dcw_unpack #(
   parameter int N_WORDS = dcw_pkg::DESC_WORDS,
   localparam int IDX_W = $clog2(N_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [31:0]        wr_data,
   output dcw_pkg::desc_t     desc
);
   generate
      if (N_WORDS != 12) begin : g_bad_layout
         $error("dcw_unpack: descriptor layout needs exactly 12 words");
      end
   endgenerate

   logic [N_WORDS-1:0][31:0] w_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q <= '0;
      end else begin
         for (int i = 0; i < N_WORDS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) w_q[i] <= wr_data;
         end
      end
   end

   always_comb begin
      desc.flags   = w_q[0];
      desc.id      = w_q[1];
      desc.dst     = {w_q[3], w_q[2]};
      desc.src     = {w_q[5], w_q[4]};
      desc.nxt     = {w_q[7], w_q[6]};
      desc.ylen    = w_q[8];
      desc.xlen    = w_q[9];
      desc.sstride = w_q[10];
      desc.dstride = w_q[11];
   end
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
   import dcw_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_desc_en,
   input  logic              cfg_cyclic_req,
   input  logic [ADDR_W-1:0] cfg_head_addr,
   input  logic              submit,
   output logic              cyclic_active,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [31:0]       rd_rsp_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_src,
   output logic [ADDR_W-1:0] cmd_dst,
   output logic [31:0]       cmd_xlen,
   output logic [31:0]       cmd_ylen,
   output logic [31:0]       cmd_src_stride,
   output logic [31:0]       cmd_dst_stride,
   input  logic              xfer_done,
   output logic              irq,
   output logic              busy,
   output logic [31:0]       cur_id
);
   localparam int IDX_W = $clog2(DESC_WORDS);

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
         $error("dchain_walker: ADDR_W must lie in 32..64");
      end
   endgenerate

   walk_st_t          st_q;
   desc_t             desc;
   logic              fetch_start;
   logic              fetch_done;
   logic [ADDR_W-1:0] fetch_base;
   logic [ADDR_W-1:0] next_addr;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [31:0]       wr_data;
   logic              irq_q;
   logic              go;
   logic              seg_end;
   logic              unused_flags;

   dcw_fetch #(.ADDR_W(ADDR_W), .N_WORDS(DESC_WORDS)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(fetch_start), .base(fetch_base),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(fetch_done));

   dcw_unpack #(.N_WORDS(DESC_WORDS)) u_unpack (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .desc(desc));

   generate
      if (ADDR_W == 64) begin : g_full_addr
         assign next_addr = desc.nxt;
         assign cmd_src   = desc.src;
         assign cmd_dst   = desc.dst;
      end else begin : g_narrow_addr
         logic unused_hi;
         assign next_addr = desc.nxt[ADDR_W-1:0];
         assign cmd_src   = desc.src[ADDR_W-1:0];
         assign cmd_dst   = desc.dst[ADDR_W-1:0];
         assign unused_hi = ^{desc.nxt[63:ADDR_W], desc.src[63:ADDR_W], desc.dst[63:ADDR_W]};
      end
   endgenerate

   assign unused_flags = ^desc.flags[31:2];

   assign go          = (st_q == ST_IDLE) && submit && cfg_desc_en;
   assign seg_end     = (st_q == ST_RUN) && xfer_done;
   assign fetch_start = go || (seg_end && !desc.flags[FLAG_LAST]);
   assign fetch_base  = (st_q == ST_IDLE) ? cfg_head_addr : next_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         irq_q <= 1'b0;
      end else begin
         irq_q <= seg_end && desc.flags[FLAG_IRQ];
         unique case (st_q)
            ST_IDLE:  if (go) st_q <= ST_FETCH;
            ST_FETCH: if (fetch_done) st_q <= ST_ISSUE;
            ST_ISSUE: if (cmd_ready) st_q <= ST_RUN;
            ST_RUN:   if (xfer_done) st_q <= desc.flags[FLAG_LAST] ? ST_IDLE : ST_FETCH;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid      = (st_q == ST_ISSUE);
   assign cmd_xlen       = desc.xlen;
   assign cmd_ylen       = desc.ylen;
   assign cmd_src_stride = desc.sstride;
   assign cmd_dst_stride = desc.dstride;
   assign cur_id         = desc.id;
   assign irq            = irq_q;
   assign busy           = (st_q != ST_IDLE);
   assign cyclic_active  = cfg_cyclic_req & ~cfg_desc_en;

   assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst)
                                  && $stable(cmd_xlen) && $stable(cur_id));

   assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req_valid && !cmd_valid);

   assert_fetch_cmd_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_valid && cmd_valid));

   assert_last_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> busy);
endmodule

// File: tb/sim_dchain_walker.sv
module sim_dchain_walker;
   localparam int AW   = 64;
   localparam int MAXD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_desc_en = 1'b0, cfg_cyclic_req = 1'b0, submit = 1'b0;
   logic [AW-1:0] cfg_head_addr = '0;
   logic          cyclic_active;
   logic          rd_req_valid, rd_req_ready = 1'b0;
   logic [AW-1:0] rd_req_addr;
   logic          rd_rsp_valid = 1'b0;
   logic [31:0]   rd_rsp_data = '0;
   logic          cmd_valid, cmd_ready = 1'b0;
   logic [AW-1:0] cmd_src, cmd_dst;
   logic [31:0]   cmd_xlen, cmd_ylen, cmd_src_stride, cmd_dst_stride;
   logic          xfer_done = 1'b0;
   logic          irq, busy;
   logic [31:0]   cur_id;

   always #10 clk = ~clk;

   dchain_walker #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_desc_en(cfg_desc_en), .cfg_cyclic_req(cfg_cyclic_req),
      .cfg_head_addr(cfg_head_addr), .submit(submit), .cyclic_active(cyclic_active),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
      .cmd_xlen(cmd_xlen), .cmd_ylen(cmd_ylen), .cmd_src_stride(cmd_src_stride),
      .cmd_dst_stride(cmd_dst_stride), .xfer_done(xfer_done), .irq(irq), .busy(busy),
      .cur_id(cur_id));

   int total = 0, bad = 0;
   bit finished = 1'b0;

   logic [31:0] mem [1024];
   logic [31:0] e_flags [MAXD], e_id [MAXD], e_x [MAXD], e_y [MAXD], e_ss [MAXD], e_ds [MAXD];
   logic [63:0] e_src [MAXD], e_dst [MAXD], e_addr [MAXD];
   int n_desc = 0, req_k = 0, req_w = 0, cmd_k = 0, done_k = 0, n_req = 0, irq_seen = 0;
   bit chain_end = 1'b0, mem_pend = 1'b0, eng_pend = 1'b0, chk_pend = 1'b0;
   bit exp_irq = 1'b0, exp_last = 1'b0;
   int mem_cnt = 0, eng_cnt = 0;
   logic [63:0] mem_addr = '0;

   task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] word_addr(int k, int w);
      return e_addr[k] + 64'(4 * w);
   endfunction

   // memory and transfer engine models, plus per-handshake checks
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_pend) begin
            check_eq("R7", "irq after done", 64'(irq), 64'(exp_irq));
            check_eq(exp_last ? "R6" : "R9", "busy after done", 64'(busy), 64'(!exp_last));
            if (exp_last) chain_end = 1'b1;
            chk_pend = 1'b0;
         end else if (irq) begin
            check_eq("R7", "stray irq", 64'(irq), 64'd0);
         end
         if (irq) irq_seen++;
         rd_rsp_valid = 1'b0;
         if (mem_pend) begin
            if (mem_cnt == 0) begin
               rd_rsp_valid = 1'b1;
               rd_rsp_data  = mem[mem_addr[11:2]];
               mem_pend     = 1'b0;
            end else mem_cnt--;
         end
         rd_req_ready = ($urandom % 4) != 0;
         xfer_done = 1'b0;
         if (eng_pend) begin
            if (eng_cnt == 0) begin
               xfer_done = 1'b1;
               eng_pend  = 1'b0;
               chk_pend  = 1'b1;
               exp_irq   = e_flags[done_k][1];
               exp_last  = e_flags[done_k][0];
               done_k++;
            end else eng_cnt--;
         end
         cmd_ready = ($urandom % 3) != 0;
         #1;
         if (rd_req_valid && rd_req_ready) begin
            if (req_k >= n_desc) check_eq("R6", "read beyond chain", 64'(req_k), 64'(n_desc));
            else check_eq("R3", "read address", rd_req_addr, word_addr(req_k, req_w));
            check_eq("R9", "busy while fetching", 64'(busy), 64'd1);
            mem_pend = 1'b1;
            mem_cnt  = $urandom % 3;
            mem_addr = rd_req_addr;
            n_req++;
            req_w++;
            if (req_w == 12) begin req_w = 0; req_k++; end
         end
         if (cmd_valid && cmd_ready) begin
            if (cmd_k >= n_desc) check_eq("R6", "command beyond chain", 64'(cmd_k), 64'(n_desc));
            else begin
               check_eq("R4", "cmd_src", cmd_src, e_src[cmd_k]);
               check_eq("R4", "cmd_dst", cmd_dst, e_dst[cmd_k]);
               check_eq("R4", "cmd_xlen", 64'(cmd_xlen), 64'(e_x[cmd_k]));
               check_eq("R4", "cmd_ylen", 64'(cmd_ylen), 64'(e_y[cmd_k]));
               check_eq("R4", "cmd_src_stride", 64'(cmd_src_stride), 64'(e_ss[cmd_k]));
               check_eq("R4", "cmd_dst_stride", 64'(cmd_dst_stride), 64'(e_ds[cmd_k]));
               check_eq("R10", "cur_id", 64'(cur_id), 64'(e_id[cmd_k]));
            end
            eng_pend = 1'b1;
            eng_cnt  = $urandom % 4;
            cmd_k++;
         end
      end
   end

   // kind: 0 random, 1 all 1D with irq, 2 minimum/maximum lengths
   task automatic run_chain(int n, int kind, bit resubmit);
      int s0;
      int exp_irqs;
      int start_req;
      logic [31:0] hi;
      s0 = $urandom % 64;
      hi = $urandom;
      exp_irqs = 0;
      for (int k = 0; k < n; k++) e_addr[k] = {hi, 32'(((s0 + 7 * k) % 64) * 64)};
      for (int k = 0; k < n; k++) begin
         logic [63:0] nx;
         bit twod;
         twod = (kind == 0) && ($urandom % 2 == 1);
         e_flags[k] = {$urandom, 2'b00} | 32'(k == n - 1);
         if (kind == 1 || (kind != 1 && $urandom % 2 == 1)) e_flags[k][1] = 1'b1;
         if (e_flags[k][1]) exp_irqs++;
         e_id[k]  = $urandom;
         e_src[k] = {$urandom, $urandom};
         e_dst[k] = {$urandom, $urandom};
         e_x[k]   = (kind == 2) ? ((k % 2 == 0) ? 32'd0 : 32'hFFFF_FFFF) : $urandom;
         e_y[k]   = twod ? $urandom : 32'd0;
         e_ss[k]  = twod ? $urandom : 32'd0;
         e_ds[k]  = twod ? $urandom : 32'd0;
         nx = (k == n - 1) ? {$urandom, $urandom} : e_addr[k + 1];
         mem[e_addr[k][11:2] + 0]  = e_flags[k];
         mem[e_addr[k][11:2] + 1]  = e_id[k];
         mem[e_addr[k][11:2] + 2]  = e_dst[k][31:0];
         mem[e_addr[k][11:2] + 3]  = e_dst[k][63:32];
         mem[e_addr[k][11:2] + 4]  = e_src[k][31:0];
         mem[e_addr[k][11:2] + 5]  = e_src[k][63:32];
         mem[e_addr[k][11:2] + 6]  = nx[31:0];
         mem[e_addr[k][11:2] + 7]  = nx[63:32];
         mem[e_addr[k][11:2] + 8]  = e_y[k];
         mem[e_addr[k][11:2] + 9]  = e_x[k];
         mem[e_addr[k][11:2] + 10] = e_ss[k];
         mem[e_addr[k][11:2] + 11] = e_ds[k];
      end
      n_desc = n; req_k = 0; req_w = 0; cmd_k = 0; done_k = 0; irq_seen = 0;
      chain_end = 1'b0;
      start_req = n_req;
      @(negedge clk);
      cfg_desc_en   = 1'b1;
      cfg_head_addr = e_addr[0];
      submit        = 1'b1;
      @(negedge clk);
      submit = 1'b0;
      check_eq("R9", "busy after submit", 64'(busy), 64'd1);
      if (resubmit) begin
         repeat (20) @(negedge clk);
         if (busy) begin
            cfg_head_addr = 64'h0000_0000_0000_0F00;
            submit = 1'b1;
            @(negedge clk);
            submit = 1'b0;
         end
      end
      for (int t = 0; t < 20000 && !chain_end; t++) @(negedge clk);
      check_eq("R6", "chain reached its end", 64'(chain_end), 64'd1);
      repeat (10) @(negedge clk);
      check_eq(resubmit ? "R8" : "R6", "commands issued", 64'(cmd_k), 64'(n));
      check_eq("R3", "reads issued", 64'(n_req - start_req), 64'(12 * n));
      check_eq("R7", "irq count", 64'(irq_seen), 64'(exp_irqs));
      check_eq("R9", "idle after chain", 64'(busy), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "busy at reset", 64'(busy), 64'd0);
      check_eq("R1", "irq at reset", 64'(irq), 64'd0);
      check_eq("R1", "rd_req_valid at reset", 64'(rd_req_valid), 64'd0);
      check_eq("R1", "cmd_valid at reset", 64'(cmd_valid), 64'd0);

      // submit with descriptor mode disabled starts nothing
      cfg_desc_en = 1'b0;
      cfg_head_addr = 64'h40;
      submit = 1'b1;
      @(negedge clk);
      submit = 1'b0;
      repeat (8) @(negedge clk);
      check_eq("R2", "no start when disabled", 64'(busy), 64'd0);
      check_eq("R2", "no read when disabled", 64'(n_req), 64'd0);

      // cyclic masking
      cfg_cyclic_req = 1'b1;
      #1 check_eq("R11", "cyclic with mode off", 64'(cyclic_active), 64'd1);
      cfg_desc_en = 1'b1;
      #1 check_eq("R11", "cyclic with mode on", 64'(cyclic_active), 64'd0);
      cfg_cyclic_req = 1'b0;
      cfg_desc_en = 1'b0;

      run_chain(1, 1, 1'b0);
      run_chain(2, 0, 1'b0);
      run_chain(3, 2, 1'b0);
      run_chain(4, 1, 1'b1);
      for (int r = 0; r < 8; r++) run_chain(1 + ($urandom % MAXD), 0, (r % 2) == 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule